// File: doc/BRIEF.md
# Manchester Frame Serializer

This block turns a byte stream into a self-clocking serial line. An upstream source offers frame bytes over a valid/ready handshake, with a flag marking the last byte. The block runs one clock per half bit, so a 20 MHz clock gives a 10 Mbit/s line. When a source has a byte waiting while the line is idle, the block starts a frame. It first sends a fixed synchronising run of alternating bits and a start delimiter, and it consumes no input while it does so. It then takes one body byte every 16 clocks and serializes the bytes least significant bit first. The body holds the header, the payload and the check bytes. The block does not compute the check bytes.

Every bit occupies two clock cycles. The line carries the inverse of the bit in the first cycle and the bit itself in the second. The block counts body bytes and rejects frames whose body is too short or too long. It also rejects a frame when the source fails to supply a byte at its slot. It reports a good frame with a one-cycle completion pulse and a rejected frame with a one-cycle error pulse. After a body that is too long, or after a missed slot, it discards the rest of that frame's input.

Top module: `mser_tx`

## Requirements
- R1: After reset, and whenever no frame is being sent, `line_out` is 0 and `tx_active`, `in_ready`, `done` and `err` are all 0.
- R2: In the clock after `in_valid` is seen high while idle, `tx_active` rises and the line sends SYNC_BYTES bytes of 0x55 and then one byte of 0xD5. No input is consumed during these bytes.
- R3: A bit b occupies two consecutive cycles. `line_out` is !b in the first cycle and b in the second. The bits of each byte go out bit 0 first.
- R4: `in_ready` is high for exactly one cycle in each transmit slot, and only there. The slots are the last cycle of the delimiter byte and the last cycle of each body byte that was not flagged last. A byte taken with `in_valid` in a slot starts on the line in the next cycle, so the line has no gaps.
- R5: After the last cycle of the byte flagged with `in_last`, `tx_active` drops and `line_out` goes idle in the next cycle. In that same cycle `done` pulses high for one cycle.
- R6: Let the body count include the byte being taken, and let MIN_BODY = HDR_BYTES+MIN_PAYLOAD+CRC_BYTES. If a byte flagged last is taken while the count is below MIN_BODY, that byte is not sent. In the next cycle `err` pulses, the line goes idle and the block returns to idle without pulsing `done`.
- R7: Let MAX_BODY = HDR_BYTES+MAX_PAYLOAD+CRC_BYTES. If a byte not flagged last is taken and brings the count to MAX_BODY, that byte is not sent. In the next cycle `err` pulses and the line goes idle. The block then holds `in_ready` high and drops every byte until it takes one flagged last.
- R8: If `in_valid` is low in a transmit slot, the next cycle pulses `err` and idles the line. The block then discards bytes as in R7.
- R9: Bodies of exactly MIN_BODY and exactly MAX_BODY bytes are sent in full and end with `done`.
- R10: If `in_valid` is high in the cycle `done` pulses, the next frame's preamble starts in the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source offers a byte; also starts a frame from idle |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte ends the frame |
| in_ready | output | 1 | Byte is taken this cycle if in_valid is high |
| line_out | output | 1 | Manchester-coded serial line |
| tx_active | output | 1 | Preamble or body on the line |
| done | output | 1 | One-cycle pulse after a good frame |
| err | output | 1 | One-cycle pulse when a frame is rejected |

## Verification
The bench keeps the preamble at seven sync bytes. It shrinks the frame limits to a 2-byte header, a 1-byte check field and a payload of 2 to 5 bytes, so a body must hold 5 to 8 bytes. With these values, the exact minimum, the exact maximum, a one-byte-short body and an overlong body with a discarded tail each cost only a few hundred cycles. A missed slot and back-to-back frames fit in the same short run. Every cycle is compared against a queue-based model of the line, and the bench also decodes the line itself back into bytes.

// File: rtl/mser_pkg.sv
package mser_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_BYTE  = 8'h55;
  localparam logic [BYTE_W-1:0] DELIM_BYTE = 8'hD5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_BODY  = 2'd2,
    ST_DRAIN = 2'd3
  } tx_state_t;

  // level of one half of a coded bit: inverse first, true value second
  function automatic logic half_level(input logic b, input logic second);
    return second ? b : ~b;
  endfunction

  // byte number idx of the lead-in: sync bytes, then one delimiter
  function automatic logic [BYTE_W-1:0] preamble_byte(input int unsigned idx,
                                                      input int unsigned n_sync);
    return (idx < n_sync) ? SYNC_BYTE : DELIM_BYTE;
  endfunction

  function automatic logic body_short(input int unsigned n_after, input logic last,
                                      input int unsigned min_n);
    return last && (n_after < min_n);
  endfunction

  function automatic logic body_long(input int unsigned n_after, input logic last,
                                     input int unsigned max_n);
    return !last && (n_after >= max_n);
  endfunction

endpackage

// File: rtl/mser_phase_ctr.sv
module mser_phase_ctr #(
  parameter int HALVES  = 16,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               run,
  output logic [PHASE_W-1:0] phase,
  output logic               byte_end
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(HALVES - 1);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (clear) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= (phase_q == LAST_PHASE) ? '0 : phase_q + 1'b1;
    end
  end

  assign phase    = phase_q;
  assign byte_end = (phase_q == LAST_PHASE);

  // a finished byte is followed by a fresh byte starting at phase zero
  assert_phase_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && byte_end && !clear) |=> (phase == '0));

endmodule

// File: rtl/mser_encoder.sv
module mser_encoder
  import mser_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b0,
  parameter int   IDX_W      = 3
) (
  input  logic              active,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              second_half,
  output logic              line
);

  logic cur_bit;

  assign cur_bit = byte_val[bit_idx];

  always_comb begin
    if (active) line = half_level(cur_bit, second_half);
    else        line = IDLE_LEVEL;
  end

endmodule

// File: rtl/mser_len_check.sv
module mser_len_check #(
  parameter int CNT_W    = 11,
  parameter int MIN_BODY = 64,
  parameter int MAX_BODY = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             take_last,
  output logic             short_hit,
  output logic             long_hit
);

  import mser_pkg::*;

  logic [CNT_W-1:0] count_q;
  int unsigned      n_after;

  assign n_after = int'(count_q) + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (take && !short_hit && !long_hit) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign short_hit = take && body_short(n_after, take_last, MIN_BODY);
  assign long_hit  = take && body_long(n_after, take_last, MAX_BODY);

  // the accepted body never grows past the largest legal size
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(MAX_BODY));

endmodule

// File: rtl/mser_tx.sv
module mser_tx
  import mser_pkg::*;
#(
  parameter int   SYNC_BYTES  = 7,
  parameter int   HDR_BYTES   = 14,
  parameter int   CRC_BYTES   = 4,
  parameter int   MIN_PAYLOAD = 46,
  parameter int   MAX_PAYLOAD = 1500,
  parameter logic IDLE_LEVEL  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              line_out,
  output logic              tx_active,
  output logic              done,
  output logic              err
);

  localparam int MIN_BODY = HDR_BYTES + MIN_PAYLOAD + CRC_BYTES;
  localparam int MAX_BODY = HDR_BYTES + MAX_PAYLOAD + CRC_BYTES;
  localparam int CNT_W    = $clog2(MAX_BODY + 1);
  localparam int HALVES   = 2 * BYTE_W;
  localparam int PHASE_W  = $clog2(HALVES);
  localparam int IDX_W    = PHASE_W - 1;
  localparam int PIDX_W   = $clog2(SYNC_BYTES + 1);
  localparam logic [PIDX_W-1:0] DELIM_IDX = PIDX_W'(SYNC_BYTES);

  tx_state_t          state_q, state_d;
  logic [BYTE_W-1:0]  cur_byte_q;
  logic               cur_last_q;
  logic [PIDX_W-1:0]  pidx_q;
  logic               done_q, err_q;

  logic [PHASE_W-1:0] phase;
  logic               byte_end;
  logic               second_half;
  logic [IDX_W-1:0]   bit_idx;

  // named events, shared by the next-state logic and the assertions
  logic in_pre, in_body, in_drain;
  logic start_evt, slot_evt, take_evt, underrun_evt;
  logic pre_step_evt, frame_end_evt, drain_end_evt, err_evt;
  logic short_hit, long_hit;

  assign in_pre   = (state_q == ST_PRE);
  assign in_body  = (state_q == ST_BODY);
  assign in_drain = (state_q == ST_DRAIN);

  assign start_evt     = (state_q == ST_IDLE) && in_valid;
  assign slot_evt      = byte_end && ((in_pre && pidx_q == DELIM_IDX) ||
                                      (in_body && !cur_last_q));
  assign take_evt      = slot_evt && in_valid;
  assign underrun_evt  = slot_evt && !in_valid;
  assign pre_step_evt  = in_pre && byte_end && (pidx_q != DELIM_IDX);
  assign frame_end_evt = in_body && byte_end && cur_last_q;
  assign drain_end_evt = in_drain && in_valid && in_last;
  assign err_evt       = underrun_evt || short_hit || long_hit;

  assign second_half = phase[0];
  assign bit_idx     = phase[PHASE_W-1:1];

  mser_phase_ctr #(
    .HALVES  (HALVES),
    .PHASE_W (PHASE_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_evt),
    .run      (tx_active),
    .phase    (phase),
    .byte_end (byte_end)
  );

  mser_len_check #(
    .CNT_W    (CNT_W),
    .MIN_BODY (MIN_BODY),
    .MAX_BODY (MAX_BODY)
  ) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_evt),
    .take      (take_evt),
    .take_last (in_last),
    .short_hit (short_hit),
    .long_hit  (long_hit)
  );

  mser_encoder #(
    .IDLE_LEVEL (IDLE_LEVEL),
    .IDX_W      (IDX_W)
  ) u_enc (
    .active      (tx_active),
    .byte_val    (cur_byte_q),
    .bit_idx     (bit_idx),
    .second_half (second_half),
    .line        (line_out)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_evt) state_d = ST_PRE;
      ST_PRE,
      ST_BODY: begin
        if (frame_end_evt) begin
          state_d = ST_IDLE;
        end else if (slot_evt) begin
          if (underrun_evt || long_hit) state_d = ST_DRAIN;
          else if (short_hit)           state_d = ST_IDLE;
          else                          state_d = ST_BODY;
        end
      end
      ST_DRAIN: if (drain_end_evt) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_byte_q <= '0;
      cur_last_q <= 1'b0;
      pidx_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= frame_end_evt;
      err_q   <= err_evt;
      if (start_evt) begin
        cur_byte_q <= preamble_byte(0, SYNC_BYTES);
        cur_last_q <= 1'b0;
        pidx_q     <= '0;
      end else if (pre_step_evt) begin
        cur_byte_q <= preamble_byte(int'(pidx_q) + 1, SYNC_BYTES);
        pidx_q     <= pidx_q + 1'b1;
      end else if (take_evt) begin
        cur_byte_q <= in_data;
        cur_last_q <= in_last;
      end
    end
  end

  assign tx_active = in_pre || in_body;
  assign in_ready  = slot_evt || in_drain;
  assign done      = done_q;
  assign err       = err_q;

  // the second half of every coded bit is the inverse of the first
  assert_manchester_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !second_half) |=> (tx_active && (line_out != $past(line_out))));

  // an offered slot while sending is never repeated in the next cycle
  assert_ready_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && in_ready) |=> !(tx_active && in_ready));

  // every frame ends with exactly one of the two outcome pulses
  assert_end_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> (done != err));

  // completion is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/mser_tx_tb.sv
module mser_tx_tb;

  localparam int SYNC  = 7;
  localparam int HDR   = 2;
  localparam int CRC   = 1;
  localparam int MINP  = 2;
  localparam int MAXP  = 5;
  localparam int MIN_B = HDR + MINP + CRC;
  localparam int MAX_B = HDR + MAXP + CRC;
  localparam int WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       in_ready, line_out, tx_active, done, err;

  always #4 clk = ~clk;

  mser_tx #(
    .SYNC_BYTES  (SYNC),
    .HDR_BYTES   (HDR),
    .CRC_BYTES   (CRC),
    .MIN_PAYLOAD (MINP),
    .MAX_PAYLOAD (MAXP),
    .IDLE_LEVEL  (1'b0)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .line_out  (line_out),
    .tx_active (tx_active),
    .done      (done),
    .err       (err)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit timed_out = 0;
  string tag;

  // reference model: queue of half-bit levels still to appear on the line
  bit mq[$];
  int m_mode = 0;        // 0 idle, 1 sending, 2 discarding
  int m_cnt  = 0;
  bit m_last_seen = 0;
  bit e_line = 0, e_act = 0, e_rdy = 0, e_done = 0, e_err = 0;

  // source feed: {last, data}
  logic [8:0] feed[$];
  int fi = 0;
  int underrun_at = -1;
  bit skipped = 0;

  // line decoder
  bit         dec_prev;
  int         dec_half = 0;
  int         dec_nbits = 0;
  logic [7:0] dec_byte;
  logic [7:0] dec[$];
  logic [7:0] exp_q[$];
  int         man_bad = 0;
  int         n_done = 0, n_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push_byte_halves(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      mq.push_back(~b[i]);
      mq.push_back(b[i]);
    end
  endtask

  task automatic model_step(output bit acc);
    acc    = 0;
    e_done = 0;
    e_err  = 0;
    case (m_mode)
      0: if (in_valid) begin
        m_mode = 1;
        mq.delete();
        for (int p = 0; p <= SYNC; p++) push_byte_halves(p < SYNC ? 8'h55 : 8'hD5);
        m_cnt = 0;
        m_last_seen = 0;
      end
      2: begin
        acc = in_valid;
        if (in_valid && in_last) m_mode = 0;
      end
      default: begin
        void'(mq.pop_front());
        if (e_rdy) begin
          if (!in_valid) begin
            e_err = 1; mq.delete(); m_mode = 2;
          end else begin
            acc = 1;
            m_cnt++;
            if (in_last && m_cnt < MIN_B) begin
              e_err = 1; mq.delete(); m_mode = 0;
            end else if (!in_last && m_cnt >= MAX_B) begin
              e_err = 1; mq.delete(); m_mode = 2;
            end else begin
              push_byte_halves(in_data);
              m_last_seen = in_last;
            end
          end
        end
        if (m_mode == 1 && mq.size() == 0) begin
          m_mode = 0;
          e_done = 1;
        end
      end
    endcase
    e_act  = (m_mode == 1);
    e_line = (e_act && mq.size() > 0) ? mq[0] : 1'b0;
    e_rdy  = (m_mode == 1 && mq.size() == 1 && !m_last_seen) || (m_mode == 2);
  endtask

  task automatic tick();
    bit acc;
    @(negedge clk);
    cycles++;
    if (cycles > WATCHDOG) timed_out = 1;
    model_step(acc);
    // R1 R3 R4 R5 compared every cycle against the model
    check({line_out, tx_active, in_ready, done, err} == {e_line, e_act, e_rdy, e_done, e_err},
          tag, "{line,active,ready,done,err}",
          int'({line_out, tx_active, in_ready, done, err}),
          int'({e_line, e_act, e_rdy, e_done, e_err}));
    if (done) n_done++;
    if (err)  n_err++;
    if (tx_active) begin
      if (dec_half == 0) begin
        dec_prev = line_out;
      end else begin
        if (line_out == dec_prev) man_bad++;
        dec_byte[dec_nbits] = line_out;
        dec_nbits++;
        if (dec_nbits == 8) begin
          dec.push_back(dec_byte);
          dec_nbits = 0;
        end
      end
      dec_half ^= 1;
    end else begin
      dec_half  = 0;
      dec_nbits = 0;
    end
    if (acc) fi++;
    if (fi < feed.size()) begin
      {in_last, in_data} = feed[fi];
      if (e_rdy && m_mode == 1 && fi == underrun_at && !skipped) begin
        in_valid = 1'b0;
        skipped  = 1;
      end else begin
        in_valid = 1'b1;
      end
    end else begin
      in_valid = 1'b0;
      in_last  = 1'b0;
      in_data  = 8'h00;
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 37) ^ (k * 91) ^ (k << 4));
  endfunction

  // adds a frame of n bytes to the feed; sent_n of them are expected on the line
  task automatic add_frame(input int n, input int seed, input int sent_n);
    logic [7:0] b;
    for (int p = 0; p <= SYNC; p++) exp_q.push_back(p < SYNC ? 8'h55 : 8'hD5);
    for (int k = 0; k < n; k++) begin
      b = (seed == 0 && k == 0) ? 8'h00 : (seed == 0 && k == 1) ? 8'hFF : pat(seed, k);
      feed.push_back({(k == n - 1), b});
      if (k < sent_n) exp_q.push_back(b);
    end
  endtask

  task automatic run_feed(input string t, input int exp_done, input int exp_err);
    tag = t;
    fi = 0; skipped = 0;
    n_done = 0; n_err = 0; man_bad = 0;
    dec.delete();
    do tick(); while (!timed_out && !(fi >= feed.size() && m_mode == 0));
    repeat (3) tick();
    check(n_done == exp_done, t, "done pulses", n_done, exp_done);
    check(n_err == exp_err, t, "err pulses", n_err, exp_err);
    check(man_bad == 0, "R3", "inverse-then-true pairs broken", man_bad, 0);
    check(fi == feed.size(), t, "bytes consumed", fi, feed.size());
    check(dec.size() == exp_q.size(), "R2", "decoded byte count", dec.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < dec.size(); i++)
      if (dec[i] != exp_q[i])
        check(0, "R4", $sformatf("decoded byte %0d", i), dec[i], exp_q[i]);
    feed.delete();
    exp_q.delete();
    underrun_at = -1;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
    tag = "R1";
    repeat (3) @(negedge clk);
    check({line_out, tx_active, in_ready, done, err} == 5'b0, "R1", "reset outputs",
          int'({line_out, tx_active, in_ready, done, err}), 0);
    rst_n = 1'b1;
    repeat (4) tick();

    add_frame(6, 0, 6);          run_feed("R5", 1, 0);
    add_frame(MIN_B, 3, MIN_B);  run_feed("R9", 1, 0);
    add_frame(MAX_B, 5, MAX_B);  run_feed("R9", 1, 0);
    add_frame(MIN_B - 1, 7, MIN_B - 2);  run_feed("R6", 0, 1);
    add_frame(MAX_B + 3, 9, MAX_B - 1);  run_feed("R7", 0, 1);
    underrun_at = 3;
    add_frame(6, 11, 3);         run_feed("R8", 0, 1);
    add_frame(MIN_B, 13, MIN_B);
    add_frame(7, 15, 7);         run_feed("R10", 2, 0);
    add_frame(7, 17, 7);         run_feed("R2", 1, 0);

    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule